// File: doc/BRIEF.md
# Low-Power Receive Error Monitor

This block watches the low-power side of a serial display link on each received data lane. It flags three kinds of protocol violation. The first is an escape entry command that the decoder does not recognise. The second is a low-power data burst whose length is not a whole number of bytes. The third is a turnaround or escape request that drops straight to Stop instead of passing through Bridge.

Each lane has its own detector. The results are packed into three status groups, one per error type, with one bit per lane in each group. A flag is sticky: it stays high, with no software action, until the sampled line state of that lane next changes, and then it clears by itself. Masking and register access belong to the surrounding logic.

The two-bit line state of a lane is read as {DP, DN}. 2'b11 is Stop, 2'b00 is Bridge, and 2'b10 and 2'b01 are the two single-ended states.

Top module: `lp_rx_err_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all nine error bits read 0.
- R2: If a lane has `esc_cmd_valid` high with `esc_cmd_known` low on a clock edge, that lane's `err_esc` bit is 1 after that edge.
- R3: An escape command with `esc_cmd_known` high raises no `err_esc` bit.
- R4: If a lane has `lpdt_end` high and the bits received since its last end are not a multiple of 8, that lane's `err_sync` bit is 1 after that edge. The bit count includes a `lpdt_bit_stb` in the same cycle as `lpdt_end`.
- R5: An end with a bit count that is a multiple of 8, including zero, raises no `err_sync` bit.
- R6: The bit count restarts from zero after every `lpdt_end`, so earlier bursts do not affect the next one.
- R7: A line-state change sequence of 11, 10, 00, then 10 or 01, then 11 sets that lane's `err_ctrl` bit after the edge that samples the final 11.
- R8: The same request sequence followed by 00 (Bridge) raises no `err_ctrl` bit.
- R9: A flag stays at its value while the lane's line state is unchanged. It reads 0 after the first edge that samples a line state different from the previous sample, unless R10 applies.
- R10: A set condition and a line-state change in the same cycle leave the flag at 1.
- R11: Lane i uses `line_state[2i+1:2i]` (bit 2i+1 is DP) and bit i of every other vector. Activity on one lane never changes another lane's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Escape-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2*NUM_LANES | Sampled {DP,DN} per lane |
| esc_cmd_valid | input | NUM_LANES | Escape entry command decoded this cycle |
| esc_cmd_known | input | NUM_LANES | Decoded escape command is recognised |
| lpdt_bit_stb | input | NUM_LANES | One low-power data bit received |
| lpdt_end | input | NUM_LANES | Low-power data transmission ended |
| err_esc | output | NUM_LANES | Unrecognised escape command flags |
| err_sync | output | NUM_LANES | Partial-byte flags |
| err_ctrl | output | NUM_LANES | Bad line-sequence flags |

## Verification
A wrong bit tally shows up as a wrong `err_sync` at the next `lpdt_end`. That could be many cycles after the fault, so the bench closes bursts of random length often. A wrong request tracker, or a missed line-state change, shows up one edge after the offending sample as a flag that is wrongly set or left uncleared. A reference model in the bench is compared with all nine bits on every cycle, so any divergence is reported within one clock.

// File: rtl/lp_err_pkg.sv
package lp_err_pkg;
  localparam logic [1:0] LS_STOP   = 2'b11;
  localparam logic [1:0] LS_BRIDGE = 2'b00;
  localparam logic [1:0] LS_HI_LO  = 2'b10;
  localparam logic [1:0] LS_LO_HI  = 2'b01;

  typedef enum logic [2:0] {
    TRK_STOP,
    TRK_ENTRY,
    TRK_BRIDGE,
    TRK_REQ,
    TRK_OTHER
  } trk_state_t;

  localparam int ERR_KINDS = 3;
  localparam int KIND_ESC  = 0;
  localparam int KIND_SYNC = 1;
  localparam int KIND_CTRL = 2;
endpackage

// File: rtl/lp_line_tracker.sv
module lp_line_tracker
  import lp_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_i,
  output logic       change_o,
  output logic       ctrl_hit_o
);
  logic [1:0] prev_q;
  trk_state_t st_q, st_d;

  assign change_o   = (line_i != prev_q);
  assign ctrl_hit_o = change_o && (st_q == TRK_REQ) && (line_i == LS_STOP);

  always_comb begin
    st_d = st_q;
    if (change_o) begin
      if (line_i == LS_STOP) begin
        st_d = TRK_STOP;
      end else begin
        unique case (st_q)
          TRK_STOP:   st_d = (line_i == LS_HI_LO)  ? TRK_ENTRY  : TRK_OTHER;
          TRK_ENTRY:  st_d = (line_i == LS_BRIDGE) ? TRK_BRIDGE : TRK_OTHER;
          TRK_BRIDGE: st_d = (line_i == LS_HI_LO || line_i == LS_LO_HI) ? TRK_REQ : TRK_OTHER;
          TRK_REQ:    st_d = TRK_OTHER;
          default:    st_d = TRK_OTHER;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= LS_STOP;
      st_q   <= TRK_STOP;
    end else begin
      prev_q <= line_i;
      st_q   <= st_d;
    end
  end

  // R7
  ctrl_hit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_hit_o |-> (line_i == LS_STOP && $past(line_i) != LS_STOP));

  // R9
  prev_follows_line_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (change_o == (line_i != $past(line_i))));
endmodule

// File: rtl/lp_bit_tally.sv
module lp_bit_tally #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb_i,
  input  logic end_i,
  output logic sync_hit_o
);
  localparam int CNT_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTE_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q;
    if (bit_stb_i) cnt_inc = (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
  end

  assign sync_hit_o = end_i && (cnt_inc != '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (end_i) cnt_q <= '0;
    else            cnt_q <= cnt_inc;
  end

  // R6
  tally_restart_chk: assert property (@(posedge clk) disable iff (rst)
    end_i |=> (cnt_q == '0));

  // R4
  sync_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
    sync_hit_o |-> end_i);

  // R5
  idle_end_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (end_i && !bit_stb_i && cnt_q == '0) |-> !sync_hit_o);
endmodule

// File: rtl/lp_sticky_flag.sv
module lp_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

  // R9
  clear_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);

  // R9
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i && !$past(rst)) |=> $stable(flag_o));
endmodule

// File: rtl/lp_lane_err_det.sv
module lp_lane_err_det
  import lp_err_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           line_i,
  input  logic                 esc_valid_i,
  input  logic                 esc_known_i,
  input  logic                 bit_stb_i,
  input  logic                 end_i,
  output logic [ERR_KINDS-1:0] err_o
);
  logic change;
  logic ctrl_hit;
  logic sync_hit;
  logic esc_hit;
  logic [ERR_KINDS-1:0] hits;

  lp_line_tracker u_trk (
    .clk(clk), .rst(rst), .line_i(line_i),
    .change_o(change), .ctrl_hit_o(ctrl_hit)
  );

  lp_bit_tally #(.BYTE_BITS(BYTE_BITS)) u_tally (
    .clk(clk), .rst(rst), .bit_stb_i(bit_stb_i), .end_i(end_i),
    .sync_hit_o(sync_hit)
  );

  assign esc_hit = esc_valid_i && !esc_known_i;

  always_comb begin
    hits            = '0;
    hits[KIND_ESC]  = esc_hit;
    hits[KIND_SYNC] = sync_hit;
    hits[KIND_CTRL] = ctrl_hit;
  end

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_flag
    lp_sticky_flag u_flag (
      .clk(clk), .rst(rst), .set_i(hits[k]), .clr_i(change), .flag_o(err_o[k])
    );
  end

  // R3
  known_esc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (esc_valid_i && esc_known_i && !err_o[KIND_ESC]) |=> !err_o[KIND_ESC]);
endmodule

// File: rtl/lp_rx_err_monitor.sv
module lp_rx_err_monitor
  import lp_err_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int BYTE_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_LANES-1:0] line_state,
  input  logic [NUM_LANES-1:0]   esc_cmd_valid,
  input  logic [NUM_LANES-1:0]   esc_cmd_known,
  input  logic [NUM_LANES-1:0]   lpdt_bit_stb,
  input  logic [NUM_LANES-1:0]   lpdt_end,
  output logic [NUM_LANES-1:0]   err_esc,
  output logic [NUM_LANES-1:0]   err_sync,
  output logic [NUM_LANES-1:0]   err_ctrl
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [ERR_KINDS-1:0] lane_err;

    lp_lane_err_det #(.BYTE_BITS(BYTE_BITS)) u_det (
      .clk(clk), .rst(rst),
      .line_i(line_state[2*i+1 -: 2]),
      .esc_valid_i(esc_cmd_valid[i]), .esc_known_i(esc_cmd_known[i]),
      .bit_stb_i(lpdt_bit_stb[i]), .end_i(lpdt_end[i]),
      .err_o(lane_err)
    );

    assign err_esc[i]  = lane_err[KIND_ESC];
    assign err_sync[i] = lane_err[KIND_SYNC];
    assign err_ctrl[i] = lane_err[KIND_CTRL];
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (err_esc == '0 && err_sync == '0 && err_ctrl == '0));

  // R2
  esc_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (esc_cmd_valid[0] && !esc_cmd_known[0]) |=> err_esc[0]);
endmodule

// File: tb/lp_rx_err_monitor_test.sv
module lp_rx_err_monitor_test;
  localparam int L = 3;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*L-1:0] line_state = '1;
  logic [L-1:0] esc_cmd_valid = '0, esc_cmd_known = '0;
  logic [L-1:0] lpdt_bit_stb = '0, lpdt_end = '0;
  logic [L-1:0] err_esc, err_sync, err_ctrl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  logic [1:0] m_prev [L];
  int         m_st   [L];   // 0 stop,1 entry,2 bridge,3 req,4 other
  int         m_cnt  [L];
  logic [L-1:0] x_esc, x_sync, x_ctrl;

  always #5 clk = ~clk;

  lp_rx_err_monitor uut (
    .clk(clk), .rst(rst), .line_state(line_state),
    .esc_cmd_valid(esc_cmd_valid), .esc_cmd_known(esc_cmd_known),
    .lpdt_bit_stb(lpdt_bit_stb), .lpdt_end(lpdt_end),
    .err_esc(err_esc), .err_sync(err_sync), .err_ctrl(err_ctrl)
  );

  function automatic int next_st(int st, logic [1:0] ls);
    if (ls == 2'b11) return 0;
    case (st)
      0: return (ls == 2'b10) ? 1 : 4;
      1: return (ls == 2'b00) ? 2 : 4;
      2: return (ls == 2'b10 || ls == 2'b01) ? 3 : 4;
      default: return 4;
    endcase
  endfunction

  function automatic logic upd(logic cur, logic hit, logic chg);
    if (hit) return 1'b1;
    if (chg) return 1'b0;
    return cur;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < L; i++) begin
      m_prev[i] = 2'b11; m_st[i] = 0; m_cnt[i] = 0;
    end
    x_esc = '0; x_sync = '0; x_ctrl = '0;
  endtask

  task automatic model_step();
    for (int i = 0; i < L; i++) begin
      logic [1:0] ls;
      logic chg;
      int tot;
      ls  = line_state[2*i +: 2];
      chg = (ls != m_prev[i]);
      tot = (m_cnt[i] + int'(lpdt_bit_stb[i])) % 8;
      x_ctrl[i] = upd(x_ctrl[i], chg && m_st[i] == 3 && ls == 2'b11, chg);
      x_esc[i]  = upd(x_esc[i], esc_cmd_valid[i] && !esc_cmd_known[i], chg);
      x_sync[i] = upd(x_sync[i], lpdt_end[i] && tot != 0, chg);
      if (chg) m_st[i] = next_st(m_st[i], ls);
      m_cnt[i]  = lpdt_end[i] ? 0 : tot;
      m_prev[i] = ls;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (err_esc !== x_esc || err_sync !== x_sync || err_ctrl !== x_ctrl) begin
      errors++;
      $display("FAIL %s: got esc=%b sync=%b ctrl=%b expected esc=%b sync=%b ctrl=%b",
               tag, err_esc, err_sync, err_ctrl, x_esc, x_sync, x_ctrl);
    end
  endtask

  task automatic expect_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // one clock: inputs already driven; model, edge, compare at negedge, idle pulses
  task automatic cyc(string tag);
    if (rst) model_reset(); else model_step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare(tag);
    esc_cmd_valid = '0; esc_cmd_known = '0; lpdt_bit_stb = '0; lpdt_end = '0;
  endtask

  task automatic set_ls(int lane, logic [1:0] v);
    line_state[2*lane +: 2] = v;
  endtask

  task automatic lane0_seq(logic [1:0] a, logic [1:0] b, string tag);
    set_ls(0, 2'b11); cyc(tag);
    set_ls(0, 2'b10); cyc(tag);
    set_ls(0, 2'b00); cyc(tag);
    set_ls(0, a);     cyc(tag);
    set_ls(0, b);     cyc(tag);
  endtask

  initial begin
    #(MAX_CYCLES * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    rst = 1'b1;
    cyc("R1 reset");
    cyc("R1 reset");
    rst = 1'b0;
    cyc("R1 after reset");
    expect_bit("R1 ctrl clear", |err_ctrl, 1'b0);

    // R2 unrecognised escape on lane 1
    esc_cmd_valid[1] = 1'b1; esc_cmd_known[1] = 1'b0; cyc("R2");
    expect_bit("R2 lane1 esc", err_esc[1], 1'b1);
    expect_bit("R11 lane0 esc untouched", err_esc[0], 1'b0);
    cyc("R9 hold");
    expect_bit("R9 esc held", err_esc[1], 1'b1);
    set_ls(1, 2'b10); cyc("R9 clear");
    expect_bit("R9 esc cleared", err_esc[1], 1'b0);
    set_ls(1, 2'b11); cyc("R9");

    // R3 recognised escape
    esc_cmd_valid[2] = 1'b1; esc_cmd_known[2] = 1'b1; cyc("R3");
    expect_bit("R3 known esc", err_esc[2], 1'b0);

    // R10 set and change together
    esc_cmd_valid[2] = 1'b1; set_ls(2, 2'b01); cyc("R10");
    expect_bit("R10 set wins", err_esc[2], 1'b1);
    set_ls(2, 2'b11); cyc("R10");

    // R4 five bits then end
    for (int b = 0; b < 5; b++) begin lpdt_bit_stb[0] = 1'b1; cyc("R4"); end
    lpdt_end[0] = 1'b1; cyc("R4");
    expect_bit("R4 partial byte", err_sync[0], 1'b1);
    set_ls(0, 2'b10); cyc("R9"); set_ls(0, 2'b11); cyc("R9");

    // R5 eight bits, last with end
    for (int b = 0; b < 7; b++) begin lpdt_bit_stb[0] = 1'b1; cyc("R5"); end
    lpdt_bit_stb[0] = 1'b1; lpdt_end[0] = 1'b1; cyc("R5");
    expect_bit("R5 full byte", err_sync[0], 1'b0);
    lpdt_end[0] = 1'b1; cyc("R5 empty end");
    expect_bit("R5 zero bits", err_sync[0], 1'b0);

    // R6 3 bits, end (flag), change clears, then 8 bits clean
    for (int b = 0; b < 3; b++) begin lpdt_bit_stb[1] = 1'b1; cyc("R6"); end
    lpdt_end[1] = 1'b1; cyc("R6");
    set_ls(1, 2'b10); cyc("R6"); set_ls(1, 2'b11); cyc("R6");
    for (int b = 0; b < 8; b++) begin lpdt_bit_stb[1] = 1'b1; cyc("R6"); end
    lpdt_end[1] = 1'b1; cyc("R6");
    expect_bit("R6 restart", err_sync[1], 1'b0);

    // R7 turnaround then stop; escape then stop
    lane0_seq(2'b10, 2'b11, "R7 ta");
    expect_bit("R7 ta stop", err_ctrl[0], 1'b1);
    lane0_seq(2'b01, 2'b11, "R7 esc");
    expect_bit("R7 esc stop", err_ctrl[0], 1'b1);
    // R8 proper bridge
    lane0_seq(2'b10, 2'b00, "R8");
    expect_bit("R8 bridge ok", err_ctrl[0], 1'b0);
    set_ls(0, 2'b11); cyc("R8 exit");
    expect_bit("R8 no late flag", err_ctrl[0], 1'b0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < L; i++) begin
        if ($urandom_range(3) == 0) set_ls(i, 2'($urandom_range(3)));
        esc_cmd_valid[i] = ($urandom_range(15) == 0);
        esc_cmd_known[i] = $urandom_range(1) == 1;
        lpdt_bit_stb[i]  = $urandom_range(1) == 1;
        lpdt_end[i]      = ($urandom_range(11) == 0);
      end
      cyc("R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule